// File: doc/BRIEF.md
# Overlapping 1101 Serial Sequence Detector

This block watches a one-bit serial stream and flags, in the same cycle, every bit that completes the sequence 1101 among the accepted bits. An accepted bit is one presented while the valid qualifier is high. Matches may overlap: the trailing 1 of one match can open the next, so the stream 1101101 produces two flags.

The detector is a four-state Mealy machine with a two-bit register. The register records how much of the sequence is already in hand: nothing, a leading 1, the pair 11, or the triple 110. The flag is a combinational function of that register and the present input. A debug output exposes the register so that the progress through the sequence can be observed.

Top module: `seqdet_1101`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state register is cleared to the idle code 00. After reset, `match` is 0 until a completing bit is presented.
- R2: `state_dbg` carries the encoded progress: 00 = nothing seen, 01 = leading 1 seen, 10 = 11 seen, 11 = 110 seen.
- R3: On an accepted bit, the next state is as follows.
  - From 00: a 0 goes to 00 and a 1 goes to 01.
  - From 01: a 0 goes to 00 and a 1 goes to 10.
  - From 10: a 0 goes to 11 and a 1 stays at 10.
  - From 11: a 0 goes to 00 and a 1 goes to 01.
- R4: `match` is 1 exactly when `in_valid` is 1, `in_bit` is 1 and `state_dbg` is 11. It changes in the same cycle as the inputs, without waiting for a clock edge.
- R5: After a match, the state is 01, so overlapping matches are found. The accepted stream 1101101 raises `match` twice, on its 4th and 7th bits.
- R6: While `in_valid` is 0, the state holds, `match` is 0 and `in_bit` has no effect.
- R7: After reset, `match` is 1 on an accepted bit exactly when that bit and the three accepted bits before it, all since reset, are 1,1,0,1 in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | High when `in_bit` carries a stream bit |
| in_bit | input | 1 | Serial data bit |
| match | output | 1 | Combinational one-cycle sequence-complete flag |
| state_dbg | output | 2 | Present state code (see R2) |

## Verification
The assertions check these rules on every cycle:
- the individual arcs of the state graph;
- the gating of the flag by the valid qualifier and the held state;
- the return to the 01 state after each match;
- the idle state on leaving reset.

Only the bench's scenarios can show that the flag agrees with the whole history of accepted bits. The bench compares it against a four-bit window model in two ways:
- over every eight-bit stream;
- over a long random stream with gaps in `in_valid` and a reset in the middle of the stream.

The directed 1101101 stream confirms the double detection.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_NONE  = 2'b00,
        ST_ONE   = 2'b01,
        ST_PAIR  = 2'b10,
        ST_TRIPLE = 2'b11
    } det_state_e;

    // Successor of a state for one accepted stream bit.
    function automatic det_state_e step_state(input det_state_e cur, input logic b);
        det_state_e nxt;
        unique case (cur)
            ST_NONE:   nxt = b ? ST_ONE  : ST_NONE;
            ST_ONE:    nxt = b ? ST_PAIR : ST_NONE;
            ST_PAIR:   nxt = b ? ST_PAIR : ST_TRIPLE;
            ST_TRIPLE: nxt = b ? ST_ONE  : ST_NONE;
            default:   nxt = ST_NONE;
        endcase
        return nxt;
    endfunction

    // Mealy flag: the arc leaving the 110 state on a 1.
    function automatic logic hit(input det_state_e cur, input logic b);
        return b & (cur == ST_TRIPLE);
    endfunction

endpackage

// File: rtl/seqdet_next.sv
module seqdet_next
    import seqdet_pkg::*;
(
    input  det_state_e cur,
    input  logic       in_valid,
    input  logic       in_bit,
    output det_state_e nxt
);
    always_comb begin
        if (in_valid) nxt = step_state(cur, in_bit);
        else          nxt = cur;
    end
endmodule

// File: rtl/seqdet_flag.sv
module seqdet_flag
    import seqdet_pkg::*;
(
    input  det_state_e cur,
    input  logic       in_valid,
    input  logic       in_bit,
    output logic       match
);
    always_comb match = in_valid & hit(cur, in_bit);
endmodule

// File: rtl/seqdet_state_reg.sv
module seqdet_state_reg
    import seqdet_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  det_state_e nxt,
    output det_state_e cur
);
    always_ff @(posedge clk) begin
        if (rst) cur <= ST_NONE;
        else     cur <= nxt;
    end
endmodule

// File: rtl/seqdet_1101.sv
module seqdet_1101
    import seqdet_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_bit,
    output logic               match,
    output logic [STATE_W-1:0] state_dbg
);
    det_state_e cur_q;
    det_state_e nxt_d;

    seqdet_next u_next (
        .cur      (cur_q),
        .in_valid (in_valid),
        .in_bit   (in_bit),
        .nxt      (nxt_d)
    );

    seqdet_state_reg u_reg (
        .clk (clk),
        .rst (rst),
        .nxt (nxt_d),
        .cur (cur_q)
    );

    seqdet_flag u_flag (
        .cur      (cur_q),
        .in_valid (in_valid),
        .in_bit   (in_bit),
        .match    (match)
    );

    assign state_dbg = cur_q;
endmodule

// File: rtl/seqdet_1101_chk.sv
module seqdet_1101_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_bit,
    input logic       match,
    input logic [1:0] state_dbg
);
    p_leave_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (state_dbg == 2'b00));

    p_pair_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_bit && state_dbg == 2'b10) |=> (state_dbg == 2'b11));

    p_other_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_bit && state_dbg != 2'b10) |=> (state_dbg == 2'b00));

    p_one_advance_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_bit && (state_dbg == 2'b01 || state_dbg == 2'b10)) |=> (state_dbg == 2'b10));

    p_match_cond_r4: assert property (@(posedge clk) disable iff (rst)
        match |-> (in_valid && in_bit && state_dbg == 2'b11));

    p_overlap_r5: assert property (@(posedge clk) disable iff (rst)
        match |=> (state_dbg == 2'b01));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(state_dbg));

    p_gate_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> !match);
endmodule

bind seqdet_1101 seqdet_1101_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_bit    (in_bit),
    .match     (match),
    .state_dbg (state_dbg)
);

// File: tb/seqdet_1101_test.sv
module seqdet_1101_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_bit = 1'b0;
    logic       match;
    logic [1:0] state_dbg;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Model: accepted bits since reset, newest in bit 0.
    logic [3:0] hist;
    int         nacc;

    always #5 clk = ~clk;

    seqdet_1101 uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .match     (match),
        .state_dbg (state_dbg)
    );

    function automatic logic [1:0] exp_state(input logic [3:0] h, input int n);
        if (n >= 3 && h[2:0] == 3'b110) return 2'b11;
        if (n >= 2 && h[1:0] == 2'b11)  return 2'b10;
        if (n >= 1 && h[0])             return 2'b01;
        return 2'b00;
    endfunction

    task automatic chk(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0d exp=%0d at %0t", req, got, exp, $time);
        end
    endtask

    task automatic chk2(input logic [1:0] got, input logic [1:0] exp, input string req);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0d exp=%0d at %0t", req, got, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        in_bit = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        hist = 4'b0;
        nacc = 0;
        #1;
        chk2(state_dbg, 2'b00, "R1 state after reset");
        chk(match, 1'b0, "R1 match after reset");
    endtask

    // Drive one cycle, check the combinational outputs, then advance the model.
    task automatic step(input logic v, input logic b);
        logic exp_m;
        @(negedge clk);
        in_valid = v;
        in_bit = b;
        #1;
        chk2(state_dbg, exp_state(hist, nacc), "R2/R3 state code");
        exp_m = v && b && nacc >= 3 && hist[2:0] == 3'b110;
        if (v) chk(match, exp_m, "R4/R7 match vs window");
        else   chk(match, 1'b0, "R6 match gated");
        if (v) begin
            hist = {hist[2:0], b};
            nacc++;
        end
    endtask

    initial begin
        int hits;
        logic [6:0] seq;
        hist = 0;
        nacc = 0;

        // R5: overlapping stream 1101101
        do_reset();
        hits = 0;
        seq = 7'b1101101;
        for (int i = 6; i >= 0; i--) begin
            step(1'b1, seq[i]);
            if (match) hits++;
        end
        checks++;
        if (hits != 2) begin
            fails++;
            $display("FAIL R5 overlap matches got=%0d exp=2", hits);
        end
        @(negedge clk);
        #1;
        chk2(state_dbg, 2'b01, "R5 state after match");

        // R6: invalid cycles do not disturb the state reached from 110
        do_reset();
        step(1'b1, 1'b1); step(1'b1, 1'b1); step(1'b1, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b0, i[0]);
        step(1'b1, 1'b1);

        // R3/R7: every 8-bit stream after a reset
        for (int p = 0; p < 256; p++) begin
            do_reset();
            for (int i = 7; i >= 0; i--) step(1'b1, p[i]);
        end

        // R6/R7/R1: random stream with gaps and a reset in the middle
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            if (i == 1500) do_reset();
            step(($urandom % 4) != 0, $urandom % 2);
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule